// File: doc/BRIEF.md
# I2C Serial EEPROM Target

This block is an I2C target that behaves like a byte-addressed serial EEPROM. It runs on a fast system clock and samples the bus clock and data lines through a synchroniser. From the synchronised lines it finds START and STOP conditions and the bus clock edges. It drives the data line only through an open-drain enable: when `sda_oe_o` is 1, the line is pulled low.

A transaction opens with a device-select byte: the fixed type nibble `1010`, then three device bits, then the read/write flag. The byte is acknowledged only when the type nibble is right and the device bits match the three strap inputs. A write carries a high and a low word-address byte, then data bytes.

Data bytes collect in a 64-entry page buffer. At STOP the buffer is committed to the internal array, and a programming timer then keeps the device busy for a parameterised number of clocks. While the timer runs, the device ignores its own address, so a master can poll until the write is done. Reads return bytes from the internal word pointer, which advances after every byte moved. A random read is an address-setting write followed by a repeated START and a read. The write-protect input blocks every change to the array.

Top module: `eeprom_i2c_target`

## Requirements
- R1: After reset the target does not pull the data line low, and its first device-select byte is acknowledged at once (no programming cycle pending).
- R2: A device-select byte, sent MSB first, is acknowledged only when bits 7:4 equal 1010, bits 3:1 equal `strap_i`, and no programming cycle is running. Otherwise the target leaves the data line released until the next START.
- R3: In a write, the target acknowledges the high and the low word-address bytes. It keeps the low ADDR_W bits of {high, low} and ignores the higher bits.
- R4: A byte write (address, one data byte, STOP) commits that byte to the array, and a later random read at that address returns it.
- R5: In a page write, the low 6 address bits advance and wrap within the current 64-byte page. When more than 64 data bytes are sent, later bytes replace the earliest ones in the buffer.
- R6: The word pointer advances by one after each data byte read or written. A current-address read continues from where the last transaction left the pointer, including a write that sent only an address.
- R7: A STOP after at least one data byte of an unprotected write starts a programming cycle of PROG_CYCLES clocks. During that cycle, device-select bytes are not acknowledged; afterwards they are.
- R8: While `wp_i` is 1, data bytes are still acknowledged, but STOP starts no programming cycle and the array keeps its previous contents.
- R9: Read data is shifted out MSB first and changes only while the bus clock is low. A master NACK ends the read, and the target releases the line.
- R10: A START seen in any state, including a repeated START inside a transaction, restarts device-select decoding.
- R11: A write that stops before any data byte modifies no location and starts no programming cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable; 1 pulls the data line low |
| strap_i | input | 3 | Device address straps compared with select bits 3:1 |
| wp_i | input | 1 | Write protect; 1 blocks all array changes |

## Verification
The bench goes after the page boundary: a write that starts two bytes before the end of a page must fold back to the start of that page. A design that carried into the next page would scatter the last bytes into a neighbouring page. It also sends 66 bytes in one page write, which catches a buffer that drops the overflow or keeps the earliest bytes instead of the latest. Polling right after STOP must see a NACK, which a design that skipped or shortened the programming cycle would fail. With write protect set, the same poll must be acknowledged and the old data read back, which exposes any design that starts a cycle or touches the array anyway. Address-only writes and strap mismatches check that a pointer update or a foreign select byte never turns into a commit or a stray drive on the line.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

   // Fixed device-type nibble carried in bits 7:4 of the select byte
   localparam logic [3:0] DEV_TYPE = 4'b1010;
   // Page geometry: 64-byte pages
   localparam int PAGE_W = 6;
   localparam int PAGE_BYTES = 1 << PAGE_W;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEV,
      ST_AHI,
      ST_ALO,
      ST_WR,
      ST_RD,
      ST_WAIT
   } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_o,
   output logic sda_o,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);

   initial begin
      assert (STAGES >= 2) else $error("i2c_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_q;
   logic              sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_q    <= 1'b1;
         sda_q    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_q    <= scl_pipe[STAGES-1];
         sda_q    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_o      = scl_pipe[STAGES-1];
   assign sda_o      = sda_pipe[STAGES-1];
   assign scl_rise_o = scl_o & ~scl_q;
   assign scl_fall_o = ~scl_o & scl_q;
   // Data edges while the clock stays high mark bus conditions
   assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
   assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
   parameter int IDX_W = 6,
   localparam int DEPTH = 1 << IDX_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  clr_i,
   input  logic                  wr_i,
   input  logic [IDX_W-1:0]      idx_i,
   input  logic [7:0]            dat_i,
   output logic [DEPTH-1:0]      vld_o,
   output logic [DEPTH-1:0][7:0] dat_o
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_ent
      logic       v_q;
      logic [7:0] d_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            v_q <= 1'b0;
            d_q <= '0;
         end else if (clr_i) begin
            v_q <= 1'b0;
         end else if (wr_i && idx_i == IDX_W'(g)) begin
            v_q <= 1'b1;
            d_q <= dat_i;
         end
      end

      assign vld_o[g] = v_q;
      assign dat_o[g] = d_q;
   end

endmodule

// File: rtl/eeprom_prog_timer.sv
module eeprom_prog_timer #(
   parameter int CYCLES = 300000,
   localparam int CW = $clog2(CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o
);

   initial begin
      assert (CYCLES >= 1) else $error("eeprom_prog_timer: CYCLES must be positive");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (start_i)        cnt_q <= CW'(CYCLES);
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/eeprom_i2c_target.sv
module eeprom_i2c_target
   import eeprom_pkg::*;
#(
   parameter int ADDR_W      = 14,
   parameter int MEM_AW      = 10,
   parameter int PROG_CYCLES = 300000,
   parameter int SYNC_STAGES = 2,
   localparam int MEM_DEPTH  = 1 << MEM_AW
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe_o,
   input  logic [2:0] strap_i,
   input  logic       wp_i
);

   initial begin
      assert (ADDR_W > PAGE_W && ADDR_W <= 16)
         else $error("eeprom_i2c_target: ADDR_W out of range");
      assert (MEM_AW >= PAGE_W && MEM_AW <= ADDR_W)
         else $error("eeprom_i2c_target: MEM_AW must lie between page width and ADDR_W");
   end

   // Bus front end
   logic scl_s, sda_s, scl_rise, scl_fall, start_e, stop_e;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_i),
      .sda_i      (sda_i),
      .scl_o      (scl_s),
      .sda_o      (sda_s),
      .scl_rise_o (scl_rise),
      .scl_fall_o (scl_fall),
      .start_o    (start_e),
      .stop_o     (stop_e)
   );

   // Transaction state
   tgt_state_e          state;
   logic [3:0]          cnt;
   logic [7:0]          sh;
   logic [7:0]          tx;
   logic [7:0]          hi_q;
   logic [ADDR_W-1:0]   ptr;
   logic                oe;
   logic                rd_go;
   logic                mack;
   logic                wr_any;
   logic                busy;

   logic [7:0]          mem [MEM_DEPTH];
   logic [7:0]          mem_rd;

   logic                frame_end;
   logic                ack_end;
   logic                rx_state;
   logic                dev_ok;
   logic                pb_wr;
   logic                pb_clr;
   logic                prog_start;

   logic [PAGE_BYTES-1:0]      pb_vld;
   logic [PAGE_BYTES-1:0][7:0] pb_dat;

   assign frame_end = scl_fall && (cnt == 4'd8) && !start_e && !stop_e;
   assign ack_end   = scl_fall && (cnt == 4'd9) && !start_e && !stop_e;
   assign rx_state  = (state == ST_DEV) || (state == ST_AHI) ||
                      (state == ST_ALO) || (state == ST_WR);
   assign dev_ok    = (sh[7:4] == DEV_TYPE) && (sh[3:1] == strap_i) && !busy;
   assign pb_wr     = frame_end && (state == ST_WR);
   assign pb_clr    = frame_end && (state == ST_ALO);
   assign prog_start = stop_e && wr_any && !wp_i && !busy;
   assign mem_rd    = mem[ptr[MEM_AW-1:0]];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         sh     <= '0;
         tx     <= '0;
         hi_q   <= '0;
         ptr    <= '0;
         oe     <= 1'b0;
         rd_go  <= 1'b0;
         mack   <= 1'b0;
         wr_any <= 1'b0;
      end else if (start_e) begin
         state <= ST_DEV;
         cnt   <= '0;
         oe    <= 1'b0;
         rd_go <= 1'b0;
      end else if (stop_e) begin
         state  <= ST_IDLE;
         cnt    <= '0;
         oe     <= 1'b0;
         rd_go  <= 1'b0;
         wr_any <= 1'b0;
      end else begin
         if (scl_rise && cnt != 4'd9) begin
            cnt <= cnt + 4'd1;
            if (rx_state && cnt < 4'd8) sh <= {sh[6:0], sda_s};
            if (state == ST_RD && cnt == 4'd8) mack <= ~sda_s;
         end
         if (frame_end) begin
            unique case (state)
               ST_DEV: begin
                  if (dev_ok) begin
                     oe    <= 1'b1;
                     rd_go <= sh[0];
                     state <= sh[0] ? ST_RD : ST_AHI;
                  end else begin
                     state <= ST_WAIT;
                  end
               end
               ST_AHI: begin
                  oe    <= 1'b1;
                  hi_q  <= sh;
                  state <= ST_ALO;
               end
               ST_ALO: begin
                  oe     <= 1'b1;
                  ptr    <= ADDR_W'({hi_q, sh});
                  wr_any <= 1'b0;
                  state  <= ST_WR;
               end
               ST_WR: begin
                  oe     <= 1'b1;
                  wr_any <= 1'b1;
                  ptr    <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + 1'b1};
               end
               ST_RD: begin
                  oe  <= 1'b0;
                  ptr <= ptr + 1'b1;
               end
               default: ;
            endcase
         end else if (ack_end) begin
            cnt <= '0;
            if (state == ST_RD && (rd_go || mack)) begin
               tx    <= mem_rd;
               oe    <= ~mem_rd[7];
               rd_go <= 1'b0;
            end else if (state == ST_RD) begin
               state <= ST_WAIT;
               oe    <= 1'b0;
            end else begin
               oe <= 1'b0;
            end
         end else if (scl_fall && state == ST_RD && cnt != 4'd0 && cnt < 4'd8) begin
            oe <= ~tx[3'd7 - cnt[2:0]];
         end
      end
   end

   eeprom_page_buf #(.IDX_W(PAGE_W)) u_pbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .clr_i (pb_clr),
      .wr_i  (pb_wr),
      .idx_i (ptr[PAGE_W-1:0]),
      .dat_i (sh),
      .vld_o (pb_vld),
      .dat_o (pb_dat)
   );

   // Whole page lands in the array on the clock that launches programming
   always_ff @(posedge clk) begin
      if (prog_start) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (pb_vld[i]) mem[{ptr[MEM_AW-1:PAGE_W], i[PAGE_W-1:0]}] <= pb_dat[i];
         end
      end
   end

   eeprom_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (prog_start),
      .busy_o  (busy)
   );

   assign sda_oe_o = oe;

endmodule

// File: rtl/eeprom_i2c_target_chk.sv
module eeprom_i2c_target_chk #(
   parameter int PROG_CYCLES = 300000,
   parameter int PAGE_HI_W   = 8
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 scl_s,
   input logic                 start_e,
   input logic                 stop_e,
   input logic                 sda_oe,
   input logic                 wp,
   input logic                 busy,
   input logic                 wr_byte,
   input logic [PAGE_HI_W-1:0] ptr_page
);

   logic [31:0] busy_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_len <= '0;
      else if (busy) busy_len <= busy_len + 1'b1;
      else           busy_len <= '0;
   end

   AST_OE_STABLE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_s && $past(scl_s) && !$past(start_e) && !$past(stop_e)) |-> $stable(sda_oe)); // R9

   AST_NO_DRIVE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> !$rose(sda_oe)); // R7

   AST_PROG_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_e)); // R7

   AST_PROG_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && $past(busy)) |-> (busy_len == PROG_CYCLES)); // R7

   AST_WP_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !$past(wp)); // R8

   AST_PAGE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      wr_byte |=> $stable(ptr_page)); // R5

endmodule

bind eeprom_i2c_target eeprom_i2c_target_chk #(
   .PROG_CYCLES (PROG_CYCLES),
   .PAGE_HI_W   (ADDR_W - eeprom_pkg::PAGE_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .start_e  (start_e),
   .stop_e   (stop_e),
   .sda_oe   (sda_oe_o),
   .wp       (wp_i),
   .busy     (busy),
   .wr_byte  (pb_wr),
   .ptr_page (ptr[ADDR_W-1:eeprom_pkg::PAGE_W])
);

// File: tb/eeprom_i2c_target_tb.sv
module eeprom_i2c_target_tb;

   localparam int Q    = 10;
   localparam int PROG = 300;

   typedef logic [7:0] bq_t[$];

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       m_scl = 1'b1;
   logic       m_sda = 1'b1;
   logic       wp = 1'b0;
   logic [2:0] strap = 3'b101;
   logic       sda_oe;
   wire        sda_line = m_sda & ~sda_oe;

   int total = 0;
   int bad = 0;
   logic [7:0] exp_q[$];
   logic [7:0] act_q[$];
   string      tag_q[$];

   always #5 clk = ~clk;

   eeprom_i2c_target #(
      .ADDR_W(14), .MEM_AW(10), .PROG_CYCLES(PROG), .SYNC_STAGES(2)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .strap_i(strap), .wp_i(wp)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // Scoreboard monitor: compares each received byte with its expectation
   initial begin
      forever begin
         @(negedge clk);
         while (act_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] a, e;
            string t;
            a = act_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(a == e, t, int'(a), int'(e));
         end
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_w(input logic b);
      wt(2); m_sda = b; wt(Q); m_scl = 1'b1; wt(Q); m_scl = 1'b0;
   endtask

   task automatic bit_r(output logic b);
      wt(2); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q/2); b = sda_line; wt(Q/2); m_scl = 1'b0;
   endtask

   task automatic i_start();
      wt(2); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b0; wt(Q); m_scl = 1'b0;
   endtask

   task automatic i_stop();
      wt(2); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
   endtask

   task automatic tx_byte(input logic [7:0] b, output bit ack);
      logic x;
      for (int i = 7; i >= 0; i--) bit_w(b[i]);
      bit_r(x);
      ack = (x == 1'b0);
   endtask

   task automatic rx_byte(output logic [7:0] b, input bit last);
      logic x;
      for (int i = 7; i >= 0; i--) begin
         bit_r(x);
         b[i] = x;
      end
      bit_w(last);
   endtask

   function automatic logic [7:0] dsel(input logic rd);
      return {4'b1010, strap, rd};
   endfunction

   task automatic set_addr(input logic [15:0] a, input string req);
      bit ack;
      i_start();
      tx_byte(dsel(1'b0), ack); chk(ack, req, ack, 1);
      tx_byte(a[15:8], ack);    chk(ack, "R3 high address ack", ack, 1);
      tx_byte(a[7:0], ack);     chk(ack, "R3 low address ack", ack, 1);
   endtask

   task automatic write_seq(input logic [15:0] a, input bq_t d, input string req);
      bit ack;
      set_addr(a, "R2 select ack on write");
      foreach (d[k]) begin
         tx_byte(d[k], ack);
         chk(ack, req, ack, 1);
      end
      i_stop();
   endtask

   task automatic read_n(input int n, input bq_t e, input string req);
      bit ack;
      logic [7:0] b;
      tx_byte(dsel(1'b1), ack); chk(ack, "R2 select ack on read", ack, 1);
      for (int k = 0; k < n; k++) begin
         exp_q.push_back(e[k]);
         tag_q.push_back(req);
         rx_byte(b, k == n - 1);
         act_q.push_back(b);
      end
      i_stop();
   endtask

   task automatic rand_read(input logic [15:0] a, input int n, input bq_t e, input string req);
      set_addr(a, "R10 select ack before repeated start");
      i_start();
      read_n(n, e, req);
   endtask

   task automatic cur_read(input int n, input bq_t e, input string req);
      i_start();
      read_n(n, e, req);
   endtask

   // Poll until the select byte is acknowledged; returns the number of NACKs seen
   task automatic poll(output int nacks);
      bit ack;
      nacks = 0;
      for (int t = 0; t < 20; t++) begin
         i_start();
         tx_byte(dsel(1'b0), ack);
         i_stop();
         if (ack) break;
         nacks++;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      bit ack;
      int n;
      bq_t d;
      wt(5);
      rst_n = 1'b1;
      wt(5);
      chk(sda_oe == 1'b0, "R1 line released after reset", sda_oe, 0);
      poll(n);
      chk(n == 0, "R1 no programming pending after reset", n, 0);

      // Foreign select bytes
      i_start();
      tx_byte({4'b1010, 3'b100, 1'b0}, ack);
      chk(!ack, "R2 strap mismatch not acked", ack, 0);
      tx_byte(8'h00, ack);
      chk(!ack, "R2 line stays released after mismatch", ack, 0);
      i_stop();
      i_start();
      tx_byte({4'b1011, strap, 1'b0}, ack);
      chk(!ack, "R2 wrong type nibble not acked", ack, 0);
      i_stop();

      // Byte write, then busy polling
      d = {8'hA5};
      write_seq(16'h0012, d, "R4 data ack");
      poll(n);
      chk(n >= 1, "R7 select nacked during programming", n, 1);
      chk(n < 20, "R7 select acked after programming", n, 19);
      d = {8'hA5};
      rand_read(16'h0012, 1, d, "R4 byte write read back");

      // Page write crossing the page end wraps to the page start
      d = {8'h10, 8'h11, 8'h12, 8'h13};
      write_seq(16'h007E, d, "R5 page data ack");
      poll(n);
      chk(n >= 1, "R7 page write programming", n, 1);
      d = {8'h12, 8'h13};
      rand_read(16'h0040, 2, d, "R5 wrapped bytes at page start");
      d = {8'h10, 8'h11};
      rand_read(16'h007E, 2, d, "R5 bytes at page end");

      // 66 bytes: the first two buffer slots are overwritten
      d = {};
      for (int i = 0; i < 66; i++) d.push_back(8'(i));
      write_seq(16'h0080, d, "R5 overflow data ack");
      poll(n);
      d = {8'd64, 8'd65, 8'd2, 8'd3};
      rand_read(16'h0080, 4, d, "R5 overflow keeps latest bytes");
      d = {8'd4};
      cur_read(1, d, "R6 R9 current address continues");

      // High address bits beyond ADDR_W are ignored
      d = {8'h5A};
      write_seq(16'hC020, d, "R3 data ack");
      poll(n);
      d = {8'h5A};
      rand_read(16'h0020, 1, d, "R3 upper address bits ignored");

      // Write protect
      wp = 1'b1;
      d = {8'hFF};
      write_seq(16'h0012, d, "R8 data acked under protect");
      poll(n);
      chk(n == 0, "R8 no programming cycle under protect", n, 0);
      wp = 1'b0;
      d = {8'hA5};
      rand_read(16'h0012, 1, d, "R8 array unchanged under protect");

      // Address-only write moves the pointer without programming
      set_addr(16'h007E, "R11 select ack");
      i_stop();
      poll(n);
      chk(n == 0, "R11 no programming after address-only write", n, 0);
      d = {8'h10, 8'h11};
      cur_read(2, d, "R6 R11 pointer set by address-only write");
      chk(sda_oe == 1'b0, "R9 line released after NACK and STOP", sda_oe, 0);

      wt(50);
      chk(exp_q.size() == 0 && act_q.size() == 0, "R9 scoreboard drained",
          act_q.size(), exp_q.size());
      summary();
      $finish;
   end

endmodule